// File: doc/BRIEF.md
# Split-Section Decade Counter

This block is a clocked model of a four-bit decade counter made of two separate sections. A one-bit half section divides its count input by two. A three-bit five-step section divides its own count input by five. Each section has its own active-low count input. Each count input passes through a two-flop synchroniser to the system clock. A falling edge on the synchronised level advances the section by one step.

A two-bit link mode selects how the sections work together. In the independent mode each section counts only its own input. In the decimal mode the half section's carry drives the five-step section, so `{five_q, half_q}` counts 0 to 9 in natural binary. In the bi-quinary mode the five-step section's wrap drives the half section, so `half_q` becomes a symmetric square wave at one tenth of the five-step input rate. A chained carry takes effect in the same system clock cycle as the edge that causes it. No count is lost.

There are two request pairs. The zero pair acts only when both inputs are high, and it clears the count. The nine pair acts only when both inputs are high, and it loads nine. Nine has priority over zero. While either pair is acting, the count is frozen, and count edges that arrive are discarded.

States and transitions. The half section has states HALF_LO and HALF_HI, and each advance toggles between them. The five-step section has states FIVE_S0 to FIVE_S4. Each advance moves S0→S1→S2→S3→S4, and S4 moves to S0. The override decoder gives one of three states: OVR_RUN (counting), OVR_ZERO (force S0/HALF_LO) or OVR_NINE (force S4/HALF_HI).

Top module: `decade_split_counter`

## Requirements
- R1: While `rst_n` is low, `half_q` is 0 and `five_q` is 3'b000.
- R2: A count input that falls and then stays low is acted on at the third rising clock edge after it was driven low. Each falling edge advances the section by exactly one step. Each level must be held for at least two clock cycles.
- R3: Each advance of the half section toggles `half_q`.
- R4: The five-step section steps `five_q` through 000, 001, 010, 011, 100 and then back to 000. Whenever `five_q[2]` is 1, `five_q[1:0]` is 00.
- R5: When `link_mode` is 2'b01 (decimal), a 1→0 step of `half_q` advances `five_q` in the same cycle. `tick_five_n` is ignored. The value `{five_q,half_q}` runs 0 to 9 and then wraps to 0.
- R6: When `link_mode` is 2'b10 (bi-quinary), the 100→000 step of `five_q` toggles `half_q` in the same cycle. `tick_two_n` is ignored. `half_q` stays low for five steps of `tick_five_n` and then high for five steps.
- R7: When `link_mode` is 2'b00 or 2'b11, the sections count their own inputs independently. Both may advance in the same cycle.
- R8: When both `zero_req_a` and `zero_req_b` are high and the nine pair is not both high, the outputs are 0 after the next rising edge and stay 0 while the condition holds.
- R9: When both `nine_req_a` and `nine_req_b` are high, `five_q`=3'b100 and `half_q`=1 after the next rising edge, whatever the zero pair is doing.
- R10: While either request pair is acting, count edges are discarded. A pair with only one input high has no effect. Counting resumes from the forced value once the pairs are released.
- R11: With no count edge and no acting request, the outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_mode | input | 2 | 00/11 independent, 01 decimal, 10 bi-quinary |
| tick_two_n | input | 1 | Count input of the half section, acts on its falling edge |
| tick_five_n | input | 1 | Count input of the five-step section, acts on its falling edge |
| zero_req_a | input | 1 | Clear request, first of a pair |
| zero_req_b | input | 1 | Clear request, second of a pair |
| nine_req_a | input | 1 | Load-nine request, first of a pair |
| nine_req_b | input | 1 | Load-nine request, second of a pair |
| half_q | output | 1 | Half section bit, weight 1 |
| five_q | output | 3 | Five-step section code, weights 8/4/2 |

## Verification
A synchronised count edge can reach a section in the same cycle that a request pair becomes active. In that case the request must win and the edge must be discarded. The bench provokes this by raising the clear pair, the nine pair, or both, while count pulses are in flight in the synchroniser, and then pulsing the inputs during the hold. A second collision happens in the chained modes: an internal carry and an edge on the ignored external input fall in the same cycle. The bench drives both count inputs together, and a behavioural reference model judges the outputs on every clock.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        LINK_NONE     = 2'b00,
        LINK_BCD      = 2'b01,
        LINK_BIQ      = 2'b10,
        LINK_NONE_ALT = 2'b11
    } link_mode_e;

    typedef enum logic [1:0] {
        OVR_RUN  = 2'b00,
        OVR_ZERO = 2'b01,
        OVR_NINE = 2'b10
    } ovr_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_state_e;

    typedef enum logic [2:0] {
        FIVE_S0 = 3'd0,
        FIVE_S1 = 3'd1,
        FIVE_S2 = 3'd2,
        FIVE_S3 = 3'd3,
        FIVE_S4 = 3'd4
    } five_state_e;

endpackage

// File: rtl/dsc_edge_sync.sv
module dsc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic fall_evt
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[DEPTH-2:0], raw_in};
        end
    end

    always_comb begin
        fall_evt = shreg[DEPTH-1] & ~shreg[DEPTH-2];
    end

    // R2
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt);

endmodule

// File: rtl/dsc_override_ctl.sv
module dsc_override_ctl
    import dsc_pkg::*;
(
    input  logic zero_a,
    input  logic zero_b,
    input  logic nine_a,
    input  logic nine_b,
    output ovr_e ovr
);
    always_comb begin
        if (nine_a && nine_b) begin
            ovr = OVR_NINE;
        end else if (zero_a && zero_b) begin
            ovr = OVR_ZERO;
        end else begin
            ovr = OVR_RUN;
        end
    end

endmodule

// File: rtl/dsc_half_stage.sv
module dsc_half_stage
    import dsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ovr_e ovr,
    input  logic adv,
    output logic bit_q,
    output logic at_hi
);
    half_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HALF_LO;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (ovr)
            OVR_NINE: state_nx = HALF_HI;
            OVR_ZERO: state_nx = HALF_LO;
            default: begin
                if (adv) begin
                    unique case (state)
                        HALF_LO: state_nx = HALF_HI;
                        HALF_HI: state_nx = HALF_LO;
                        default: state_nx = HALF_LO;
                    endcase
                end
            end
        endcase
    end

    always_comb begin
        bit_q = (state == HALF_HI);
        at_hi = (state == HALF_HI);
    end

    // R3
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr == OVR_RUN && adv) |=> (bit_q != $past(bit_q)));

endmodule

// File: rtl/dsc_five_stage.sv
module dsc_five_stage
    import dsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ovr_e       ovr,
    input  logic       adv,
    output logic [2:0] code_q,
    output logic       at_top
);
    five_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FIVE_S0;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (ovr)
            OVR_NINE: state_nx = FIVE_S4;
            OVR_ZERO: state_nx = FIVE_S0;
            default: begin
                if (adv) begin
                    unique case (state)
                        FIVE_S0: state_nx = FIVE_S1;
                        FIVE_S1: state_nx = FIVE_S2;
                        FIVE_S2: state_nx = FIVE_S3;
                        FIVE_S3: state_nx = FIVE_S4;
                        FIVE_S4: state_nx = FIVE_S0;
                        default: state_nx = FIVE_S0;
                    endcase
                end
            end
        endcase
    end

    always_comb begin
        unique case (state)
            FIVE_S0: code_q = 3'b000;
            FIVE_S1: code_q = 3'b001;
            FIVE_S2: code_q = 3'b010;
            FIVE_S3: code_q = 3'b011;
            FIVE_S4: code_q = 3'b100;
            default: code_q = 3'b000;
        endcase
        at_top = (state == FIVE_S4);
    end

    // R4
    five_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_q[2] |-> (code_q[1:0] == 2'b00));

    // R4
    five_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr == OVR_RUN && adv && code_q == 3'b100) |=> (code_q == 3'b000));

endmodule

// File: rtl/decade_split_counter.sv
module decade_split_counter
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] link_mode,
    input  logic       tick_two_n,
    input  logic       tick_five_n,
    input  logic       zero_req_a,
    input  logic       zero_req_b,
    input  logic       nine_req_a,
    input  logic       nine_req_b,
    output logic       half_q,
    output logic [2:0] five_q
);
    localparam int NSEC = 2;

    logic [NSEC-1:0] raw_tick;
    logic [NSEC-1:0] fall_evt;
    ovr_e            ovr;
    link_mode_e      mode;
    logic            half_at_hi;
    logic            five_at_top;
    logic            half_adv;
    logic            five_adv;

    assign raw_tick = {tick_five_n, tick_two_n};

    for (genvar g = 0; g < NSEC; g++) begin : g_sync
        dsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_tick[g]),
            .fall_evt (fall_evt[g])
        );
    end

    dsc_override_ctl u_ovr (
        .zero_a (zero_req_a),
        .zero_b (zero_req_b),
        .nine_a (nine_req_a),
        .nine_b (nine_req_b),
        .ovr    (ovr)
    );

    // Carries use the raw edge and the source's state, which avoids a loop
    // through the other section's advance mux.
    always_comb begin
        mode = link_mode_e'(link_mode);
        unique case (mode)
            LINK_BCD: begin
                half_adv = fall_evt[0];
                five_adv = fall_evt[0] & half_at_hi;
            end
            LINK_BIQ: begin
                half_adv = fall_evt[1] & five_at_top;
                five_adv = fall_evt[1];
            end
            default: begin
                half_adv = fall_evt[0];
                five_adv = fall_evt[1];
            end
        endcase
    end

    dsc_half_stage u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .ovr   (ovr),
        .adv   (half_adv),
        .bit_q (half_q),
        .at_hi (half_at_hi)
    );

    dsc_five_stage u_five (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovr    (ovr),
        .adv    (five_adv),
        .code_q (five_q),
        .at_top (five_at_top)
    );

    // R9
    nine_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_req_a && nine_req_b) |=> (half_q == 1'b1 && five_q == 3'b100));

    // R8
    zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_req_a && zero_req_b && !(nine_req_a && nine_req_b))
            |=> (half_q == 1'b0 && five_q == 3'b000));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt == '0 && !(zero_req_a && zero_req_b) && !(nine_req_a && nine_req_b))
            |=> $stable({five_q, half_q}));

    // R5
    bcd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == 2'b01 && fall_evt[0] && half_q
            && !(zero_req_a && zero_req_b) && !(nine_req_a && nine_req_b))
            |=> (five_q != $past(five_q)));

    // R6
    biq_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mode == 2'b10 && fall_evt[1] && five_q == 3'b100
            && !(zero_req_a && zero_req_b) && !(nine_req_a && nine_req_b))
            |=> (half_q != $past(half_q)));

endmodule

// File: tb/tb_decade_split_counter.sv
`timescale 1ns/1ps
module tb_decade_split_counter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] link_mode;
    logic       tick_two_n, tick_five_n;
    logic       zero_req_a, zero_req_b, nine_req_a, nine_req_b;
    logic       half_q;
    logic [2:0] five_q;

    always #2.5 clk = ~clk;

    decade_split_counter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_mode   (link_mode),
        .tick_two_n  (tick_two_n),
        .tick_five_n (tick_five_n),
        .zero_req_a  (zero_req_a),
        .zero_req_b  (zero_req_b),
        .nine_req_a  (nine_req_a),
        .nine_req_b  (nine_req_b),
        .half_q      (half_q),
        .five_q      (five_q)
    );

    int    compared   = 0;
    int    mismatched = 0;
    string req        = "R1";
    bit    done       = 1'b0;

    // behavioural reference: value of each section as integers
    int m_two  = 0;
    int m_five = 0;
    bit ha[$] = '{1'b0, 1'b0, 1'b0};
    bit hb[$] = '{1'b0, 1'b0, 1'b0};

    always @(posedge clk) begin
        bit fa, fb;
        int cnt;
        if (!rst_n) begin
            m_two = 0; m_five = 0;
            ha = '{1'b0, 1'b0, 1'b0};
            hb = '{1'b0, 1'b0, 1'b0};
        end else begin
            fa = ha[2] && !ha[1];
            fb = hb[2] && !hb[1];
            if (nine_req_a && nine_req_b) begin
                m_two = 1; m_five = 4;
            end else if (zero_req_a && zero_req_b) begin
                m_two = 0; m_five = 0;
            end else begin
                case (link_mode)
                    2'b01: if (fa) begin
                        cnt = (m_five * 2 + m_two + 1) % 10;
                        m_five = cnt / 2;
                        m_two  = cnt % 2;
                    end
                    2'b10: if (fb) begin
                        m_five = (m_five + 1) % 5;
                        if (m_five == 0) m_two = 1 - m_two;
                    end
                    default: begin
                        if (fa) m_two = 1 - m_two;
                        if (fb) m_five = (m_five + 1) % 5;
                    end
                endcase
            end
            ha.push_front(tick_two_n);  void'(ha.pop_back());
            hb.push_front(tick_five_n); void'(hb.pop_back());
        end
    end

    // compare on every clock
    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (half_q !== m_two[0] || five_q !== m_five[2:0]) begin
                mismatched++;
                $display("FAIL %s: got five=%b half=%b expected five=%b half=%b at %0t",
                         req, five_q, half_q, m_five[2:0], m_two[0], $time);
            end
        end
    end

    task automatic check(string r, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d at %0t", r, got, exp, $time);
        end
    endtask

    function automatic int value();
        return {five_q, half_q};
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit on_two, bit on_five);
        if (on_two)  tick_two_n  = 1'b0;
        if (on_five) tick_five_n = 1'b0;
        tick(2);
        tick_two_n = 1'b1; tick_five_n = 1'b1;
        tick(2);
    endtask

    task automatic clear_now();
        zero_req_a = 1'b1; zero_req_b = 1'b1;
        tick(1);
        zero_req_a = 1'b0; zero_req_b = 1'b0;
        tick(1);
    endtask

    initial begin
        rst_n = 1'b0; link_mode = 2'b00;
        tick_two_n = 1'b1; tick_five_n = 1'b1;
        zero_req_a = 1'b0; zero_req_b = 1'b0;
        nine_req_a = 1'b0; nine_req_b = 1'b0;
        tick(3);
        req = "R1"; check("R1 reset value", value(), 0);
        rst_n = 1'b1;
        tick(4);

        // R2 latency: acted on at third rising edge
        req = "R2";
        tick_two_n = 1'b0;
        tick(1); check("R2 not yet (1)", value(), 0);
        tick(1); check("R2 not yet (2)", value(), 0);
        tick(1); check("R2 acted on edge 3", value(), 1);
        tick_two_n = 1'b1; tick(3);

        // R3/R4/R7 independent sections
        req = "R3_R4_R7";
        for (int i = 0; i < 6; i++) pulse(1'b0, 1'b1);
        check("R4 five after 6 steps", five_q, 1);
        check("R3 half unchanged by five input", half_q, 1);
        for (int i = 0; i < 7; i++) pulse(1'b1, (i % 2) == 0);
        link_mode = 2'b11;
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1);
        check("R7 alt independent half", half_q, 1);

        // R5 decimal chain
        req = "R5";
        link_mode = 2'b01; clear_now();
        for (int i = 0; i < 9; i++) pulse(1'b1, 1'b0);
        check("R5 reaches nine", value(), 9);
        pulse(1'b1, 1'b1);
        check("R5 wraps to zero, five input ignored", value(), 0);
        for (int i = 0; i < 14; i++) pulse(1'b1, (i % 3) == 0);
        check("R5 count 14 mod 10", value(), 4);

        // R6 bi-quinary chain
        req = "R6";
        link_mode = 2'b10; clear_now();
        for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1);
        check("R6 half high after five steps", half_q, 1);
        check("R6 five back at zero", five_q, 0);
        for (int i = 0; i < 5; i++) pulse(1'b0, 1'b1);
        check("R6 half low after ten steps", half_q, 0);
        for (int i = 0; i < 8; i++) pulse(1'b0, 1'b1);

        // R8 clear mid-count with edges in flight
        req = "R8";
        link_mode = 2'b01; clear_now();
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0);
        tick_two_n = 1'b0; tick(1);
        zero_req_a = 1'b1; zero_req_b = 1'b1;
        tick(2); tick_two_n = 1'b1; tick(2);
        pulse(1'b1, 1'b1); pulse(1'b1, 1'b0);
        check("R8 held at zero", value(), 0);
        zero_req_a = 1'b0; zero_req_b = 1'b0; tick(1);
        req = "R10";
        pulse(1'b1, 1'b0);
        check("R10 resumes from zero", value(), 1);

        // R9 nine mid-count, then together with clear
        req = "R9";
        pulse(1'b1, 1'b0);
        nine_req_a = 1'b1; nine_req_b = 1'b1;
        tick(1); check("R9 loads nine", value(), 9);
        zero_req_a = 1'b1; zero_req_b = 1'b1;
        pulse(1'b1, 1'b0);
        check("R9 wins over clear", value(), 9);
        nine_req_a = 1'b0; nine_req_b = 1'b0;
        tick(1); check("R8 clear after nine release", value(), 0);
        zero_req_a = 1'b0; zero_req_b = 1'b0; tick(1);

        // R10 single-sided requests have no effect
        req = "R10";
        zero_req_a = 1'b1; nine_req_b = 1'b1;
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        check("R10 single requests ignored", value(), 3);
        zero_req_a = 1'b0; nine_req_b = 1'b0;
        zero_req_b = 1'b1; nine_req_a = 1'b1;
        pulse(1'b1, 1'b0);
        check("R10 other single requests ignored", value(), 4);
        zero_req_b = 1'b0; nine_req_a = 1'b0;

        // R11 idle hold
        req = "R11";
        tick(20);
        check("R11 value held while idle", value(), 4);

        // nine then resume counting in decimal: 9 -> 0
        req = "R9";
        nine_req_a = 1'b1; nine_req_b = 1'b1; tick(1);
        nine_req_a = 1'b0; nine_req_b = 1'b0; tick(1);
        pulse(1'b1, 1'b0);
        check("R9 count resumes from nine", value(), 0);

        done = 1'b1;
        tick(1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule